// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block runs one acquisition on an external eight-channel, 16-bit simultaneous-sampling ADC that has a serial readout. A start request raises a convert strobe for a fixed minimum width. The block then waits out the conversion time and clocks the results out of the converter in 32-bit serial frames. There is no chip select: the convert strobe alone marks the start of an acquisition.

Each frame holds two channel results. The upper half belongs to the higher channel and the lower half to the channel just below it. Readout always begins at the top channel and moves downward. Every result is sign-extended and presented on a sample stream together with its channel index. The number of channels to read and the serial clock divider are captured when a start is accepted. `busy` and a one-cycle `done` frame the whole operation.

Top module: `adc_cnv_seq`

## Requirements
- R1: Each accepted start produces exactly one convert pulse on `adc_cnv`, high for CNV_CYC clock cycles (the smallest number of clock periods covering 30 ns; 8 at a 4 ns clock).
- R2: `adc_sclk` is low whenever the block is idle or the convert strobe is high. After the strobe falls, `adc_sclk` stays low for CONV_CYC cycles (450 ns rounded up to whole clocks; 113 at 4 ns) plus the low phase of one serial bit before it first rises.
- R3: A frame is 32 rising edges of `adc_sclk`. `adc_sdo` is sampled on each rising edge, and the first bit of a frame is its MSB. Frames follow each other back to back, and an acquisition of N channels gives exactly 16·N rising edges.
- R4: Samples appear on `smp_data` with `smp_valid` high, one per cycle. The upper 16 bits of a frame are output first with the higher channel index, then the lower 16 bits with the index one below. Indices run from 7 downward in steps of one, and the last one is 8−N.
- R5: The 16-bit two's-complement sample is sign-extended to the full `smp_data` width.
- R6: `nch_req` is captured at start. The values 2, 4, 6 and 8 select that many channels; any other value selects 8.
- R7: `div_req` is captured at start and gives the serial clock period D in clock cycles. `adc_sclk` is high for floor(D/2) cycles and low for the rest of each period. Values 0 and 1 select D = 8.
- R8: A start request while `busy` is high is ignored: there is no second convert pulse and the running acquisition is unchanged.
- R9: `done` is high for exactly one cycle, after the last `smp_valid` of the acquisition, and `busy` is low in that cycle.
- R10: During and after reset, with no start request, `adc_cnv`, `adc_sclk`, `smp_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one acquisition |
| nch_req | input | 4 | Number of channels to read (2, 4, 6, 8) |
| div_req | input | 8 | Serial clock period in system cycles |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Convert strobe |
| adc_sclk | output | 1 | Serial clock, idles low |
| smp_valid | output | 1 | Sample stream valid |
| smp_data | output | 32 | Sign-extended sample |
| smp_ch | output | 3 | Channel index of the sample |
| busy | output | 1 | Acquisition in progress |
| done | output | 1 | One-cycle end-of-acquisition pulse |

## Verification
The embedded properties check the following on every cycle: the convert pulse width, the serial clock staying low while the strobe is high or the block is idle, the descending index within a sample pair, sign extension, start rejection while busy, and `done` being a single-cycle pulse with `busy` low. Some behaviours can only be shown by the bench scenarios, where a converter model shifts out known channel values. These are the conversion wait measured in cycles, the serial clock period and duty for several divider values, the edge count per acquisition, the bit order, the pairing of frame halves to channels, and the fallback for illegal channel counts and divider values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CNV,
      ST_WAIT,
      ST_SHIFT,
      ST_TAIL
   } seq_state_t;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

   AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero); // R1

endmodule

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             sclk,
   output logic             smp,
   output logic             per_end
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_nxt;
   logic [DIV_W-1:0] lo_len;

   assign lo_len  = div - (div >> 1);
   assign cnt_nxt = (cnt_q == div - 1'b1) ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sclk  <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         sclk  <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         sclk  <= (cnt_nxt >= lo_len);
      end
   end

   assign smp     = en && (cnt_q == lo_len - 1'b1);
   assign per_end = en && (cnt_q == div - 1'b1);

   AST_SMP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      smp |=> sclk); // R3

   AST_SMP_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      smp |-> !sclk); // R3

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
   parameter int FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               smp,
   input  logic               sdi,
   output logic [FRAME_W-1:0] word,
   output logic               frame_done
);

   localparam int BC_W = $clog2(FRAME_W);

   logic [BC_W-1:0] bitcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word       <= '0;
         bitcnt_q   <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (clr) begin
            bitcnt_q <= '0;
         end else if (smp) begin
            word <= {word[FRAME_W-2:0], sdi};
            if (bitcnt_q == BC_W'(FRAME_W - 1)) begin
               bitcnt_q   <= '0;
               frame_done <= 1'b1;
            end else begin
               bitcnt_q <= bitcnt_q + 1'b1;
            end
         end
      end
   end

   AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done); // R3

endmodule

// File: rtl/adc_cnv_seq.sv
module adc_cnv_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int SAMPLE_W    = 16,
   parameter int OUT_W       = 32,
   parameter int DIV_W       = 8,
   parameter int DEFAULT_DIV = 8,
   parameter int CLK_PS      = 4000,
   parameter int CNV_MIN_PS  = 30000,
   parameter int CONV_PS     = 450000,
   parameter int NCH_W       = $clog2(NUM_CH + 1),
   parameter int CH_W        = $clog2(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NCH_W-1:0] nch_req,
   input  logic [DIV_W-1:0] div_req,
   input  logic             adc_sdo,
   output logic             adc_cnv,
   output logic             adc_sclk,
   output logic             smp_valid,
   output logic [OUT_W-1:0] smp_data,
   output logic [CH_W-1:0]  smp_ch,
   output logic             busy,
   output logic             done
);

   localparam int FRAME_W  = 2 * SAMPLE_W;
   localparam int CNV_CYC  = int'(ceil_div(CNV_MIN_PS, CLK_PS));
   localparam int CONV_CYC = int'(ceil_div(CONV_PS, CLK_PS));
   localparam int TMR_W    = $clog2(int'(max2(CNV_CYC, CONV_CYC)) + 1);
   localparam int FR_W     = $clog2(NUM_CH / 2 + 1);

   if (NUM_CH < 2 || (NUM_CH % 2) != 0) begin : g_bad_nch
      $error("NUM_CH must be even and at least 2");
   end
   if (OUT_W < SAMPLE_W) begin : g_bad_out
      $error("OUT_W must not be narrower than SAMPLE_W");
   end
   if (DEFAULT_DIV < 2 || DEFAULT_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("DEFAULT_DIV must be at least 2 and fit in DIV_W");
   end
   if (CNV_CYC < 1 || CONV_CYC < 1) begin : g_bad_time
      $error("timing windows must cover at least one clock");
   end

   seq_state_t         state_q;
   logic [DIV_W-1:0]   div_q;
   logic [FR_W-1:0]    frames_rem_q;
   logic [CH_W-1:0]    ch_hi_q;
   logic [CH_W-1:0]    ch_lo_q;
   logic [SAMPLE_W-1:0] low_hold_q;
   logic               pend_q;

   logic               accept;
   logic [NCH_W-1:0]   nch_ok;
   logic [DIV_W-1:0]   div_ok;
   logic               nch_legal;

   logic               tmr_load;
   logic [TMR_W-1:0]   tmr_val;
   logic               tmr_zero;

   logic               sclk_en;
   logic               smp;
   logic               per_end;
   logic [FRAME_W-1:0] word;
   logic               frame_done;
   logic               last_frame_end;

   logic [SAMPLE_W-1:0] raw_sel;
   logic [OUT_W-1:0]    raw_ext;

   assign accept    = (state_q == ST_IDLE) && start;
   assign nch_legal = (nch_req != '0) && !nch_req[0] && (nch_req <= NCH_W'(NUM_CH));
   assign nch_ok    = nch_legal ? nch_req : NCH_W'(NUM_CH);
   assign div_ok    = (div_req < DIV_W'(2)) ? DIV_W'(DEFAULT_DIV) : div_req;

   assign tmr_load  = accept || ((state_q == ST_CNV) && tmr_zero);
   assign tmr_val   = (state_q == ST_IDLE) ? TMR_W'(CNV_CYC - 1) : TMR_W'(CONV_CYC - 1);
   assign sclk_en   = (state_q == ST_SHIFT);

   assign last_frame_end = per_end &&
      ((frames_rem_q == '0) || ((frames_rem_q == FR_W'(1)) && frame_done));

   adc_seq_timer #(
      .CNT_W (TMR_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   adc_seq_sclk #(
      .DIV_W (DIV_W)
   ) u_sclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (sclk_en),
      .div     (div_q),
      .sclk    (adc_sclk),
      .smp     (smp),
      .per_end (per_end)
   );

   adc_seq_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (accept),
      .smp        (smp),
      .sdi        (adc_sdo),
      .word       (word),
      .frame_done (frame_done)
   );

   // Sequencer control
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         adc_cnv      <= 1'b0;
         busy         <= 1'b0;
         done         <= 1'b0;
         div_q        <= DIV_W'(DEFAULT_DIV);
         frames_rem_q <= '0;
      end else begin
         done <= 1'b0;
         if (frame_done && frames_rem_q != '0) begin
            frames_rem_q <= frames_rem_q - 1'b1;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q      <= ST_CNV;
                  adc_cnv      <= 1'b1;
                  busy         <= 1'b1;
                  div_q        <= div_ok;
                  frames_rem_q <= FR_W'(nch_ok >> 1);
               end
            end
            ST_CNV: begin
               if (tmr_zero) begin
                  adc_cnv <= 1'b0;
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tmr_zero) begin
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (last_frame_end) begin
                  state_q <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (!frame_done && !pend_q) begin
                  state_q <= ST_IDLE;
                  busy    <= 1'b0;
                  done    <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Frame unpacking: upper half first, lower half one cycle later
   assign raw_sel = frame_done ? word[FRAME_W-1:SAMPLE_W] : low_hold_q;

   if (OUT_W > SAMPLE_W) begin : g_sext
      assign raw_ext = {{(OUT_W - SAMPLE_W){raw_sel[SAMPLE_W-1]}}, raw_sel};
   end else begin : g_plain
      assign raw_ext = raw_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_valid  <= 1'b0;
         smp_data   <= '0;
         smp_ch     <= '0;
         pend_q     <= 1'b0;
         low_hold_q <= '0;
         ch_hi_q    <= CH_W'(NUM_CH - 1);
         ch_lo_q    <= '0;
      end else begin
         if (accept) begin
            ch_hi_q <= CH_W'(NUM_CH - 1);
         end
         if (frame_done) begin
            smp_valid  <= 1'b1;
            smp_data   <= raw_ext;
            smp_ch     <= ch_hi_q;
            low_hold_q <= word[SAMPLE_W-1:0];
            ch_lo_q    <= ch_hi_q - 1'b1;
            ch_hi_q    <= ch_hi_q - CH_W'(2);
            pend_q     <= 1'b1;
         end else if (pend_q) begin
            smp_valid <= 1'b1;
            smp_data  <= raw_ext;
            smp_ch    <= ch_lo_q;
            pend_q    <= 1'b0;
         end else begin
            smp_valid <= 1'b0;
         end
      end
   end

   // Checking logic: width of the running convert pulse
   logic [15:0] cnv_len_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnv_len_q <= '0;
      end else begin
         cnv_len_q <= adc_cnv ? cnv_len_q + 1'b1 : '0;
      end
   end

   AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cnv) |-> (cnv_len_q == 16'(CNV_CYC))); // R1

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !adc_sclk); // R2

   AST_NO_SCLK_IN_CNV: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cnv |-> !adc_sclk); // R2

   AST_PAIR_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && $past(smp_valid)) |-> (smp_ch == CH_W'($past(smp_ch) - 1'b1))); // R4

   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> busy); // R4

   if (OUT_W > SAMPLE_W) begin : g_sext_chk
      AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
         smp_valid |-> ((smp_data[OUT_W-1:SAMPLE_W-1] == '0) ||
                        (smp_data[OUT_W-1:SAMPLE_W-1] == '1))); // R5
   end

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cnv) |-> !$past(busy)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

endmodule

// File: tb/adc_cnv_seq_tb.sv
module adc_cnv_seq_tb;

   localparam int CNV_EXP  = 8;
   localparam int CONV_EXP = 113;

   logic        clk;
   logic        rst_n;
   logic        start;
   logic [3:0]  nch_req;
   logic [7:0]  div_req;
   logic        adc_sdo;
   logic        adc_cnv;
   logic        adc_sclk;
   logic        smp_valid;
   logic [31:0] smp_data;
   logic [2:0]  smp_ch;
   logic        busy;
   logic        done;

   int checks;
   int failures;
   logic [127:0] adc_sr;

   adc_cnv_seq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .nch_req   (nch_req),
      .div_req   (div_req),
      .adc_sdo   (adc_sdo),
      .adc_cnv   (adc_cnv),
      .adc_sclk  (adc_sclk),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .smp_ch    (smp_ch),
      .busy      (busy),
      .done      (done)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   // {nch[27:24], div[23:16], base[15:0]}
   localparam logic [27:0] VEC [0:6] = '{
      {4'd8, 8'd8, 16'h8001},
      {4'd2, 8'd2, 16'h7FFF},
      {4'd4, 8'd4, 16'h1234},
      {4'd6, 8'd6, 16'hC0DE},
      {4'd8, 8'd3, 16'h0F0F},
      {4'd3, 8'd5, 16'hA5A5},
      {4'd0, 8'd0, 16'h4000}
   };

   function automatic logic [15:0] chan_val(input int ch, input logic [15:0] base);
      return base + 16'(ch) * 16'h2B3D;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_acq(input int nch_in, input int div_in, input logic [15:0] base,
                          input bit poke);
      int n_exp, d_exp;
      int cnv_rises, cnv_hi, gap, rises, per_bad, hi_bad, hi_run, got, last_rise;
      int data_bad, ch_bad, done_w;
      bit fell, seen_rise, prev_cnv, prev_sclk, finished;
      n_exp = (nch_in == 2 || nch_in == 4 || nch_in == 6 || nch_in == 8) ? nch_in : 8;
      d_exp = (div_in < 2) ? 8 : div_in;
      cnv_rises = 0; cnv_hi = 0; gap = 0; rises = 0; per_bad = 0; hi_bad = 0;
      hi_run = 0; got = 0; last_rise = 0; data_bad = 0; ch_bad = 0; done_w = 0;
      fell = 0; seen_rise = 0; prev_cnv = 0; prev_sclk = 0; finished = 0;
      @(negedge clk);
      nch_req = 4'(nch_in);
      div_req = 8'(div_in);
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      for (int cyc = 0; cyc < 8000 && !finished; cyc++) begin
         if (poke) start = (cyc == 40 || cyc == 300);
         if (adc_cnv && !prev_cnv) begin
            cnv_rises++;
            for (int c = 0; c < 8; c++) adc_sr[16*c +: 16] = chan_val(c, base);
         end
         if (adc_cnv) cnv_hi++;
         if (!adc_cnv && prev_cnv) fell = 1;
         if (fell && !seen_rise && !adc_sclk) gap++;
         if (adc_sclk && !prev_sclk) begin
            rises++;
            if (seen_rise && (cyc - last_rise) != d_exp) per_bad++;
            last_rise = cyc;
            seen_rise = 1;
            hi_run = 0;
         end
         if (adc_sclk) hi_run++;
         if (!adc_sclk && prev_sclk) begin
            if (hi_run != d_exp / 2) hi_bad++;
            adc_sr = adc_sr << 1;
         end
         adc_sdo = adc_sr[127];
         if (smp_valid) begin
            if (smp_ch != 3'(7 - got)) ch_bad++;
            if (smp_data != 32'(signed'(chan_val(7 - got, base)))) data_bad++;
            got++;
         end
         if (done_w > 0) begin
            check(!done, "R9 done width", 2, 1);
            finished = 1;
         end else if (done) begin
            done_w = 1;
            check(!busy, "R9 busy low at done", longint'(busy), 0);
            check(got == n_exp, "R9 done after last sample", got, n_exp);
         end
         prev_cnv  = adc_cnv;
         prev_sclk = adc_sclk;
         @(negedge clk);
      end
      start = 1'b0;
      check(finished, "R9 watchdog acquisition end", longint'(finished), 1);
      check(cnv_rises == 1, poke ? "R8 single convert pulse" : "R1 convert pulse count",
            cnv_rises, 1);
      check(cnv_hi == CNV_EXP, "R1 convert width", cnv_hi, CNV_EXP);
      check(gap == CONV_EXP + (d_exp - d_exp / 2), "R2 conversion wait", gap,
            CONV_EXP + (d_exp - d_exp / 2));
      check(rises == 16 * n_exp, "R3 serial clock edges", rises, 16 * n_exp);
      check(per_bad == 0, "R7 serial clock period", per_bad, 0);
      check(hi_bad == 0, "R7 serial clock high phase", hi_bad, 0);
      check(got == n_exp, "R6 sample count", got, n_exp);
      check(ch_bad == 0, "R4 channel order", ch_bad, 0);
      check(data_bad == 0, "R5 R3 sample values", data_bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      checks = 0;
      failures = 0;
      adc_sr = '0;
      rst_n = 1'b0;
      start = 1'b0;
      nch_req = 4'd8;
      div_req = 8'd8;
      adc_sdo = 1'b0;
      repeat (4) @(negedge clk);
      check(!adc_cnv && !adc_sclk && !smp_valid && !busy && !done, "R10 in reset",
            longint'({adc_cnv, adc_sclk, smp_valid, busy, done}), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!adc_cnv && !adc_sclk && !smp_valid && !busy && !done, "R10 after reset",
            longint'({adc_cnv, adc_sclk, smp_valid, busy, done}), 0);

      for (int v = 0; v < 7; v++) begin
         run_acq(int'(VEC[v][27:24]), int'(VEC[v][23:16]), VEC[v][15:0], 1'b0);
      end

      // Illegal channel count and divider both fall back to defaults (R6, R7)
      run_acq(10, 1, 16'hFFFF, 1'b0);
      // Start requests during an acquisition are ignored (R8)
      run_acq(4, 8, 16'h5555, 1'b1);

      repeat (20) @(negedge clk);
      check(!adc_cnv && !busy, "R8 no late convert", longint'({adc_cnv, busy}), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule